// File: doc/BRIEF.md
# Paged Memory Mapper Controller

This block lets an 8-bit CPU with a 64K address space reach up to 512K of external SRAM through a slot connector. The CPU space is cut into four 16K pages; each page owns a five-bit block-select register naming one of 32 blocks of 16K. On every memory cycle the top two CPU address bits pick a page register. That register's contents become the upper SRAM address bits, while the fourteen offset bits run from the CPU to the SRAM on board wiring and do not pass through the block.

Software loads the page registers with I/O writes to a group of four consecutive ports and reads them back over the same bidirectional data bus. The block drives the bus only while a register read is in progress. The SRAM strobes follow the slot select, read and write lines of the slot directly. After reset the four pages already map to four distinct blocks in descending order, so a system without mapper-aware firmware still sees 64K of contiguous RAM.

Top module: `page_mapper`

## Requirements
- R1: While `rst` is high, and afterwards until the first register write, pages 0, 1, 2 and 3 select blocks 3, 2, 1 and 0.
- R2: An I/O write (`iorq_n`=0, `wr_n`=0) to port 0xFC+n (n = 0..3, decoded on `cpu_addr[7:0]`) loads `data_io[4:0]` into the register of page n. Bits 7:5 of the written byte are discarded.
- R3: The write is committed once, on the first clock edge at which the qualified strobe is seen active. Later changes of the data while the same strobe stays active do not alter the register.
- R4: Writes to a port outside 0xFC..0xFF, and writes with `iorq_n` high, leave every register unchanged.
- R5: `sram_addr_hi` equals the register of the page given by `cpu_addr[15:14]`, for every page and every block value.
- R6: An I/O read (`iorq_n`=0, `rd_n`=0) of port 0xFC+n drives `data_io` with {3'b111, register n}.
- R7: In every other cycle the block leaves `data_io` undriven.
- R8: `sram_ce_n`, `sram_oe_n` and `sram_we_n` follow `slt_sel_n`, `rd_n` and `wr_n` respectively.
- R9: Raising `rst` after writes restores the values of R1.
- R10: A write that targets the page currently addressed changes `sram_addr_hi` only after the committing clock edge. Before that edge the old block is still shown.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; strobes are sampled on its rising edge |
| rst | input | 1 | Active-high reset; reloads the descending block pattern |
| cpu_addr | input | 16 | CPU address; bits 15:14 pick a page, bits 7:0 give the I/O port |
| iorq_n | input | 1 | Active-low I/O request |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| slt_sel_n | input | 1 | Active-low slot select for memory cycles |
| data_io | inout | 8 | Shared CPU data bus; driven by the block only for register reads |
| sram_addr_hi | output | 5 | Upper SRAM address bits (block number) |
| sram_ce_n | output | 1 | SRAM chip enable, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| sram_we_n | output | 1 | SRAM write enable, active low |

## Verification
A register write and the address translation can fall in the same cycle, when the CPU writes the register of the very page that `cpu_addr[15:14]` selects. The bench provokes this by holding the upper address bits on the written page while the I/O write is applied. It reads `sram_addr_hi` just before the committing edge and expects the old block, then reads it again just after and expects the new one. Holding the strobe over several edges while changing the data shows that only the first edge counts.

// File: rtl/mapper_pkg.sv
package mapper_pkg;

    localparam int BUS_W = 8;

    typedef logic [BUS_W-1:0] bus_byte_t;

    // Power-on block of a page: descending order, page 0 gets the highest.
    function automatic int unsigned boot_block(input int unsigned page,
                                               input int unsigned npage);
        return npage - 1 - page;
    endfunction

endpackage

// File: rtl/mapper_port_decode.sv
module mapper_port_decode #(
    parameter int                  PAGE_BITS = 2,
    parameter logic [7:0]          PORT_BASE = 8'hFC
) (
    input  logic [7:0]             port_addr,
    input  logic                   iorq_n,
    input  logic                   rd_n,
    input  logic                   wr_n,
    output logic                   wr_qual,
    output logic                   rd_qual,
    output logic [PAGE_BITS-1:0]   port_page
);
    localparam int HI_W = 8 - PAGE_BITS;

    logic port_hit;

    always_comb begin
        port_hit  = (port_addr[7:PAGE_BITS] == PORT_BASE[7:PAGE_BITS]);
        port_page = port_addr[PAGE_BITS-1:0];
        wr_qual   = port_hit && !iorq_n && !wr_n;
        rd_qual   = port_hit && !iorq_n && !rd_n;
    end

    logic [HI_W-1:0] unused_width_tag;
    assign unused_width_tag = '0;

endmodule

// File: rtl/mapper_page_regs.sv
module mapper_page_regs
    import mapper_pkg::*;
#(
    parameter int PAGE_BITS = 2,
    parameter int BLK_W     = 5,
    localparam int NPAGE    = 1 << PAGE_BITS
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            wr_qual,
    input  logic [PAGE_BITS-1:0]            wr_page,
    input  logic [BLK_W-1:0]                wr_blk,
    output logic [NPAGE-1:0][BLK_W-1:0]     blk_q
);
    typedef struct packed {
        logic                        strobe;
        logic [NPAGE-1:0][BLK_W-1:0] blk;
    } regs_t;

    regs_t s_d, s_q;
    regs_t s_boot;

    always_comb begin
        s_boot.strobe = 1'b0;
        for (int p = 0; p < NPAGE; p++) begin
            s_boot.blk[p] = BLK_W'(boot_block(p, NPAGE));
        end
    end

    // Next-state: commit on the onset of the qualified strobe only.
    always_comb begin
        s_d        = s_q;
        s_d.strobe = wr_qual;
        if (wr_qual && !s_q.strobe) begin
            s_d.blk[wr_page] = wr_blk;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= s_boot;
        end else begin
            s_q <= s_d;
        end
    end

    assign blk_q = s_q.blk;

endmodule

// File: rtl/mapper_xlate.sv
module mapper_xlate
    import mapper_pkg::*;
#(
    parameter int PAGE_BITS = 2,
    parameter int BLK_W     = 5,
    localparam int NPAGE    = 1 << PAGE_BITS,
    localparam int FILL_W   = BUS_W - BLK_W
) (
    input  logic [NPAGE-1:0][BLK_W-1:0] blk_q,
    input  logic [PAGE_BITS-1:0]        mem_page,
    input  logic [PAGE_BITS-1:0]        rd_page,
    output logic [BLK_W-1:0]            addr_hi,
    output bus_byte_t                   rd_byte
);
    generate
        if (FILL_W > 0) begin : g_fill
            always_comb rd_byte = {{FILL_W{1'b1}}, blk_q[rd_page]};
        end else begin : g_nofill
            always_comb rd_byte = blk_q[rd_page][BUS_W-1:0];
        end
    endgenerate

    always_comb addr_hi = blk_q[mem_page];

endmodule

// File: rtl/page_mapper.sv
module page_mapper
    import mapper_pkg::*;
#(
    parameter int         PAGE_BITS = 2,
    parameter int         BLK_W     = 5,
    parameter logic [7:0] PORT_BASE = 8'hFC,
    localparam int        NPAGE     = 1 << PAGE_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [15:0]       cpu_addr,
    input  logic              iorq_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              slt_sel_n,
    inout  wire  [7:0]        data_io,
    output logic [BLK_W-1:0]  sram_addr_hi,
    output logic              sram_ce_n,
    output logic              sram_oe_n,
    output logic              sram_we_n
);
    logic                        wr_qual;
    logic                        bus_oe;
    logic [PAGE_BITS-1:0]        port_page;
    logic [NPAGE-1:0][BLK_W-1:0] blk_q;
    bus_byte_t                   rd_byte;

    mapper_port_decode #(
        .PAGE_BITS (PAGE_BITS),
        .PORT_BASE (PORT_BASE)
    ) u_decode (
        .port_addr (cpu_addr[7:0]),
        .iorq_n    (iorq_n),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .wr_qual   (wr_qual),
        .rd_qual   (bus_oe),
        .port_page (port_page)
    );

    mapper_page_regs #(
        .PAGE_BITS (PAGE_BITS),
        .BLK_W     (BLK_W)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_qual (wr_qual),
        .wr_page (port_page),
        .wr_blk  (data_io[BLK_W-1:0]),
        .blk_q   (blk_q)
    );

    mapper_xlate #(
        .PAGE_BITS (PAGE_BITS),
        .BLK_W     (BLK_W)
    ) u_xlate (
        .blk_q    (blk_q),
        .mem_page (cpu_addr[15:16-PAGE_BITS]),
        .rd_page  (port_page),
        .addr_hi  (sram_addr_hi),
        .rd_byte  (rd_byte)
    );

    assign data_io = bus_oe ? rd_byte : 'z;

    always_comb begin
        sram_ce_n = slt_sel_n;
        sram_oe_n = rd_n;
        sram_we_n = wr_n;
    end

endmodule

// File: rtl/page_mapper_chk.sv
module page_mapper_chk #(
    parameter int         PAGE_BITS = 2,
    parameter int         BLK_W     = 5,
    parameter logic [7:0] PORT_BASE = 8'hFC,
    localparam int        NPAGE     = 1 << PAGE_BITS
) (
    input logic              clk,
    input logic              rst,
    input logic [15:0]       cpu_addr,
    input logic              iorq_n,
    input logic              rd_n,
    input logic              wr_n,
    input logic              slt_sel_n,
    input logic [7:0]        data_io,
    input logic [BLK_W-1:0]  sram_addr_hi,
    input logic              sram_ce_n,
    input logic              sram_oe_n,
    input logic              sram_we_n,
    input logic              bus_oe
);
    logic chk_qual, chk_qual_q, chk_onset;

    assign chk_qual  = !iorq_n && !wr_n &&
                       (cpu_addr[7:PAGE_BITS] == PORT_BASE[7:PAGE_BITS]);
    assign chk_onset = chk_qual && !chk_qual_q;

    always_ff @(posedge clk) begin
        if (rst) chk_qual_q <= 1'b0;
        else     chk_qual_q <= chk_qual;
    end

    // R1
    boot_pattern_chk: assert property (@(posedge clk)
        rst |=> (sram_addr_hi == BLK_W'(NPAGE - 1 - int'(cpu_addr[15:16-PAGE_BITS])))
              || chk_onset);

    // R4
    no_stray_write_chk: assert property (@(posedge clk) disable iff (rst)
        !chk_onset |=> (!$stable(cpu_addr[15:16-PAGE_BITS]) || $stable(sram_addr_hi)));

    // R3
    held_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (chk_qual && chk_qual_q) |=> (!$stable(cpu_addr[15:16-PAGE_BITS]) || $stable(sram_addr_hi)));

    // R7
    bus_drive_chk: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> (!iorq_n && !rd_n));

    // R6
    readback_fill_chk: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> (data_io[7:BLK_W] == '1));

    // R8
    strobe_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (sram_ce_n == slt_sel_n) && (sram_oe_n == rd_n) && (sram_we_n == wr_n));

endmodule

bind page_mapper page_mapper_chk #(
    .PAGE_BITS (PAGE_BITS),
    .BLK_W     (BLK_W),
    .PORT_BASE (PORT_BASE)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cpu_addr     (cpu_addr),
    .iorq_n       (iorq_n),
    .rd_n         (rd_n),
    .wr_n         (wr_n),
    .slt_sel_n    (slt_sel_n),
    .data_io      (data_io),
    .sram_addr_hi (sram_addr_hi),
    .sram_ce_n    (sram_ce_n),
    .sram_oe_n    (sram_oe_n),
    .sram_we_n    (sram_we_n),
    .bus_oe       (bus_oe)
);

// File: tb/page_mapper_test.sv
module page_mapper_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = 16'h0000;
    logic        iorq_n = 1'b1;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic        slt_sel_n = 1'b1;
    logic [7:0]  tb_drv = 8'h00;
    logic        tb_en = 1'b1;
    wire  [7:0]  dbus;
    logic [4:0]  sram_addr_hi;
    logic        sram_ce_n, sram_oe_n, sram_we_n;

    int n_chk = 0;
    int n_fail = 0;
    logic [4:0] model [4];

    assign dbus = tb_en ? tb_drv : 'z;

    always #2.5 clk = ~clk;

    page_mapper uut (
        .clk          (clk),
        .rst          (rst),
        .cpu_addr     (cpu_addr),
        .iorq_n       (iorq_n),
        .rd_n         (rd_n),
        .wr_n         (wr_n),
        .slt_sel_n    (slt_sel_n),
        .data_io      (dbus),
        .sram_addr_hi (sram_addr_hi),
        .sram_ce_n    (sram_ce_n),
        .sram_oe_n    (sram_oe_n),
        .sram_we_n    (sram_we_n)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic io_write(input logic [7:0] port, input logic [7:0] val, input logic use_iorq);
        @(negedge clk);
        cpu_addr[7:0] = port;
        tb_drv = val;
        tb_en  = 1'b1;
        iorq_n = !use_iorq;
        wr_n   = 1'b0;
        @(negedge clk);
        iorq_n = 1'b1;
        wr_n   = 1'b1;
        tb_drv = 8'h00;
    endtask

    task automatic io_read(input logic [7:0] port, output logic [7:0] val);
        @(negedge clk);
        cpu_addr[7:0] = port;
        tb_en  = 1'b0;
        iorq_n = 1'b0;
        rd_n   = 1'b0;
        #1 val = dbus;
        @(negedge clk);
        iorq_n = 1'b1;
        rd_n   = 1'b1;
        tb_drv = 8'h00;
        tb_en  = 1'b1;
    endtask

    // Checks every page through read-back and translation against the model.
    task automatic sweep(input string tag_rb, input string tag_tr);
        logic [7:0] rb;
        for (int p = 0; p < 4; p++) begin
            io_read(8'hFC + 8'(p), rb);
            check(tag_rb, rb, {3'b111, model[p]});
            cpu_addr[15:14] = 2'(p);
            #1 check(tag_tr, {3'b000, sram_addr_hi}, {3'b000, model[p]});
        end
    endtask

    task automatic boot_model();
        for (int p = 0; p < 4; p++) model[p] = 5'(3 - p);
    endtask

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] rb;
        boot_model();
        repeat (3) @(negedge clk);
        // R1: translation while reset is still held
        for (int p = 0; p < 4; p++) begin
            cpu_addr[15:14] = 2'(p);
            #0.5 check("R1", {3'b000, sram_addr_hi}, 8'(3 - p));
        end
        @(negedge clk);
        rst = 1'b0;
        // R1 / R6: after reset, before any write
        sweep("R1", "R1");

        // R7: idle bus not driven (bench pull value 00 must survive)
        @(negedge clk);
        tb_drv = 8'h00; tb_en = 1'b1;
        #1 check("R7", dbus, 8'h00);
        // R7: memory read cycle does not drive the bus
        rd_n = 1'b0; slt_sel_n = 1'b0; cpu_addr[7:0] = 8'hFD;
        #1 check("R7", dbus, 8'h00);
        // R8: strobes pass through
        check("R8", {5'b0, sram_ce_n, sram_oe_n, sram_we_n}, {5'b0, 1'b0, 1'b0, 1'b1});
        rd_n = 1'b1; wr_n = 1'b0;
        #1 check("R8", {5'b0, sram_ce_n, sram_oe_n, sram_we_n}, {5'b0, 1'b0, 1'b1, 1'b0});
        wr_n = 1'b1; slt_sel_n = 1'b1;
        #1 check("R8", {5'b0, sram_ce_n, sram_oe_n, sram_we_n}, 8'h07);

        // R2 / R5 / R6: exhaustive block values on every page, upper bits varied
        for (int v = 0; v < 32; v++) begin
            for (int p = 0; p < 4; p++) begin
                logic [4:0] bv;
                bv = 5'((v + 7 * p) % 32);
                io_write(8'hFC + 8'(p), {3'(v + p), bv}, 1'b1);
                model[p] = bv;
            end
            sweep("R2_R6", "R5");
        end

        // R4: writes outside the port group or without iorq
        io_write(8'hFB, 8'h15, 1'b1);
        io_write(8'h7C, 8'h16, 1'b1);
        io_write(8'h00, 8'h17, 1'b1);
        io_write(8'hFE, 8'h18, 1'b0);
        sweep("R4", "R4");

        // R3: hold strobe over three edges, data changes after the first
        @(negedge clk);
        cpu_addr[7:0] = 8'hFD; tb_drv = 8'h0A; tb_en = 1'b1;
        iorq_n = 1'b0; wr_n = 1'b0;
        @(negedge clk); tb_drv = 8'h1B;
        @(negedge clk); tb_drv = 8'h1C;
        @(negedge clk); iorq_n = 1'b1; wr_n = 1'b1; tb_drv = 8'h00;
        model[1] = 5'h0A;
        sweep("R3", "R3");

        // R10: write into the page currently addressed
        @(negedge clk);
        cpu_addr[15:14] = 2'd2;
        cpu_addr[7:0] = 8'hFE; tb_drv = 8'h13; tb_en = 1'b1;
        iorq_n = 1'b0; wr_n = 1'b0;
        #1 check("R10", {3'b000, sram_addr_hi}, {3'b000, model[2]});
        @(posedge clk);
        #1 check("R10", {3'b000, sram_addr_hi}, 8'h13);
        @(negedge clk); iorq_n = 1'b1; wr_n = 1'b1; tb_drv = 8'h00;
        model[2] = 5'h13;
        sweep("R10", "R10");

        // R9: reset after writes restores boot pattern
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        boot_model();
        sweep("R9", "R9");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule